// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data-memory addresses for circular buffers of the kind a signal-processing core walks through when running filters and transforms. It keeps thirty-two register sets, arranged as two banks (primary and secondary) of sixteen sets. Each set holds an index pointer, a signed modifier, a base address and a length. A request on a generator port returns the current index of the chosen set as the address. On the same clock edge, the index is replaced by its post-modified value. When that value leaves the buffer, it is folded back inside. This costs no extra cycle, and the buffer may sit at any base address with any length.

Two generator ports run side by side, so two data buses can each receive an address in the same cycle. A configuration port writes any field of any set and reads it back combinationally. One bank-select input picks which of the two banks the configuration port and both generator ports see. The bank that is not selected keeps its contents untouched.

Top module: `cbag_top`

## Requirements
- R1: After reset every field of every set in both banks reads as zero.
- R2: With `cfg_we` high, `cfg_wdata` is written at the clock edge into the field chosen by `cfg_field` of set `cfg_set` in the bank chosen by `bank_sel`. `cfg_field` codes are 0 index, 1 modifier, 2 base, 3 length. With `cfg_we` low, `cfg_rdata` shows that field combinationally.
- R3: While `gen_req[p]` is high, `gen_addr` slice p (bits p*AW upward) equals the index of set `gen_set` slice p in the selected bank before modification. At the next edge that index takes its post-modified value.
- R4: If index plus modifier is at or above base plus length, the new index is that sum minus the length.
- R5: If index plus modifier is below the base, the new index is that sum plus the length. This is how a negative (two's-complement) modifier wraps.
- R6: With a length of zero the set uses linear addressing: the new index is index plus modifier, modulo 2^AW.
- R7: Writes and pointer updates touch only the bank chosen by `bank_sel`. The other bank's fields are unchanged.
- R8: Both generator ports can serve different sets in the same cycle, and each set advances by its own modifier.
- R9: When both ports request the same set in one cycle, both return the same address and the index advances by one modifier step, not two.
- R10: When a configuration write to an index and a generator update of the same index fall in the same cycle, the generator still returns the old index, and the written value is what remains after the edge.
- R11: Wrapping works for a base that is not aligned and a length that is not a power of two.
- R12: In a cycle with no write and no request, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | 0 selects the primary bank, 1 the secondary bank |
| cfg_we | input | 1 | Configuration write enable |
| cfg_set | input | 4 | Set number for configuration access |
| cfg_field | input | 2 | Field code: 0 index, 1 modifier, 2 base, 3 length |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Combinational read of the selected field |
| gen_req | input | 2 | One address request per generator port |
| gen_set | input | 8 | Set number per port, 4 bits each, port 0 in the low bits |
| gen_addr | output | 32 | Address per port, 16 bits each, port 0 in the low bits |

## Verification
A configuration write to an index and a generator post-modify of that same index can land on one clock edge. The bench provokes this by issuing a port-0 request and an index write to the same set in the same cycle. It judges the result by comparing the returned address with the old pointer and the read-back after the edge with the written value. It also drives both ports at one set together and confirms a single modifier step, which shows the two update paths merge into one write rather than stacking.

// File: rtl/cbag_pkg.sv
package cbag_pkg;
    // Field selector codes of the configuration port
    typedef enum logic [1:0] {
        FLD_INDEX  = 2'd0,
        FLD_MODIFY = 2'd1,
        FLD_BASE   = 2'd2,
        FLD_LENGTH = 2'd3
    } cbag_field_e;
endpackage

// File: rtl/cbag_wrap.sv
module cbag_wrap #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] mod,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);
    localparam int XW = AW + 2;

    logic signed [XW-1:0] sum;
    logic signed [XW-1:0] lo;
    logic signed [XW-1:0] hi;
    logic signed [XW-1:0] span;
    logic signed [XW-1:0] adj;

    always_comb begin
        sum  = $signed({2'b00, idx}) + $signed({{2{mod[AW-1]}}, mod});
        lo   = $signed({2'b00, base});
        span = $signed({2'b00, len});
        hi   = lo + span;
        if (len == '0) begin
            adj = sum;                 // linear mode
        end else if (sum >= hi) begin
            adj = sum - span;          // ran past the top
        end else if (sum < lo) begin
            adj = sum + span;          // ran below the base
        end else begin
            adj = sum;
        end
        nxt = adj[AW-1:0];
    end
endmodule

// File: rtl/cbag_regfile.sv
module cbag_regfile
    import cbag_pkg::*;
#(
    parameter  int AW    = 16,
    parameter  int NSETS = 16,
    parameter  int NPORT = 2,
    localparam int SW    = $clog2(NSETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank,
    input  logic              cfg_we,
    input  logic [SW-1:0]     cfg_set,
    input  logic [1:0]        cfg_field,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    input  logic [NPORT-1:0]  upd_en,
    input  logic [NPORT*SW-1:0] upd_set,
    input  logic [NPORT*AW-1:0] upd_val,
    output logic [NPORT*AW-1:0] rd_idx,
    output logic [NPORT*AW-1:0] rd_mod,
    output logic [NPORT*AW-1:0] rd_base,
    output logic [NPORT*AW-1:0] rd_len
);
    localparam int NENT = 2 * NSETS;
    localparam int EW   = SW + 1;

    logic [AW-1:0] idx_q  [NENT];
    logic [AW-1:0] mod_q  [NENT];
    logic [AW-1:0] base_q [NENT];
    logic [AW-1:0] len_q  [NENT];

    logic [EW-1:0] cfg_ent;
    cbag_field_e   fld;

    assign cfg_ent = {bank, cfg_set};
    assign fld     = cbag_field_e'(cfg_field);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NENT; e++) begin
                idx_q[e]  <= '0;
                mod_q[e]  <= '0;
                base_q[e] <= '0;
                len_q[e]  <= '0;
            end
        end else begin
            for (int e = 0; e < NENT; e++) begin
                // highest port first so that port 0 lands last and wins
                for (int p = NPORT - 1; p >= 0; p--) begin
                    if (upd_en[p] && ({bank, upd_set[p*SW +: SW]} == EW'(e)))
                        idx_q[e] <= upd_val[p*AW +: AW];
                end
                // configuration write overrides any pointer update
                if (cfg_we && (cfg_ent == EW'(e))) begin
                    unique case (fld)
                        FLD_INDEX:  idx_q[e]  <= cfg_wdata;
                        FLD_MODIFY: mod_q[e]  <= cfg_wdata;
                        FLD_BASE:   base_q[e] <= cfg_wdata;
                        FLD_LENGTH: len_q[e]  <= cfg_wdata;
                    endcase
                end
            end
        end
    end

    always_comb begin
        unique case (fld)
            FLD_INDEX:  cfg_rdata = idx_q[cfg_ent];
            FLD_MODIFY: cfg_rdata = mod_q[cfg_ent];
            FLD_BASE:   cfg_rdata = base_q[cfg_ent];
            FLD_LENGTH: cfg_rdata = len_q[cfg_ent];
        endcase
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        logic [EW-1:0] ent;
        assign ent                = {bank, upd_set[p*SW +: SW]};
        assign rd_idx[p*AW +: AW]  = idx_q[ent];
        assign rd_mod[p*AW +: AW]  = mod_q[ent];
        assign rd_base[p*AW +: AW] = base_q[ent];
        assign rd_len[p*AW +: AW]  = len_q[ent];
    end
endmodule

// File: rtl/cbag_top.sv
module cbag_top #(
    parameter  int AW    = 16,
    parameter  int NSETS = 16,
    parameter  int NPORT = 2,
    localparam int SW    = $clog2(NSETS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bank_sel,
    input  logic                 cfg_we,
    input  logic [SW-1:0]        cfg_set,
    input  logic [1:0]           cfg_field,
    input  logic [AW-1:0]        cfg_wdata,
    output logic [AW-1:0]        cfg_rdata,
    input  logic [NPORT-1:0]     gen_req,
    input  logic [NPORT*SW-1:0]  gen_set,
    output logic [NPORT*AW-1:0]  gen_addr
);
    logic [NPORT*AW-1:0] rd_idx;
    logic [NPORT*AW-1:0] rd_mod;
    logic [NPORT*AW-1:0] rd_base;
    logic [NPORT*AW-1:0] rd_len;
    logic [NPORT*AW-1:0] wr_nxt;

    cbag_regfile #(
        .AW    (AW),
        .NSETS (NSETS),
        .NPORT (NPORT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank      (bank_sel),
        .cfg_we    (cfg_we),
        .cfg_set   (cfg_set),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .upd_en    (gen_req),
        .upd_set   (gen_set),
        .upd_val   (wr_nxt),
        .rd_idx    (rd_idx),
        .rd_mod    (rd_mod),
        .rd_base   (rd_base),
        .rd_len    (rd_len)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        cbag_wrap #(.AW(AW)) u_wrap (
            .idx  (rd_idx[p*AW +: AW]),
            .mod  (rd_mod[p*AW +: AW]),
            .base (rd_base[p*AW +: AW]),
            .len  (rd_len[p*AW +: AW]),
            .nxt  (wr_nxt[p*AW +: AW])
        );
    end

    // address is the pointer before modification
    assign gen_addr = rd_idx;
endmodule

// File: rtl/cbag_checker.sv
module cbag_checker #(
    parameter int AW    = 16,
    parameter int SW    = 4,
    parameter int NPORT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_sel,
    input logic              cfg_we,
    input logic [SW-1:0]     cfg_set,
    input logic [1:0]        cfg_field,
    input logic [AW-1:0]     cfg_wdata,
    input logic [AW-1:0]     cfg_rdata,
    input logic [NPORT-1:0]  gen_req,
    input logic [SW-1:0]     set0,
    input logic [AW-1:0]     addr0,
    input logic [AW-1:0]     nxt0,
    input logic [AW-1:0]     mod0,
    input logic [AW-1:0]     base0,
    input logic [AW-1:0]     len0
);
    logic [AW:0]   end0;
    logic [AW-1:0] mag0;
    logic          addr_in;
    logic          nxt_in;
    logic          look_idx0;

    assign end0      = {1'b0, base0} + {1'b0, len0};
    assign mag0      = mod0[AW-1] ? (~mod0 + 1'b1) : mod0;
    assign addr_in   = ({1'b0, addr0} >= {1'b0, base0}) && ({1'b0, addr0} < end0);
    assign nxt_in    = ({1'b0, nxt0} >= {1'b0, base0}) && ({1'b0, nxt0} < end0);
    assign look_idx0 = gen_req[0] && (cfg_field == 2'd0) && (cfg_set == set0);

    p_addr_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        look_idx0 |-> (addr0 == cfg_rdata));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (look_idx0 && !cfg_we) |=>
        (!($stable(bank_sel) && $stable(cfg_set) && $stable(cfg_field))
         || (cfg_rdata == $past(nxt0))));

    p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req[0] && (len0 != '0) && addr_in && (mag0 < len0)) |-> nxt_in);

    p_linear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req[0] && (len0 == '0)) |-> (nxt0 == AW'(addr0 + mod0)));

    p_cfg_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (look_idx0 && cfg_we) |=>
        (!($stable(bank_sel) && $stable(cfg_set) && $stable(cfg_field))
         || (cfg_rdata == $past(cfg_wdata))));

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && (gen_req == '0)) |=>
        (!($stable(bank_sel) && $stable(cfg_set) && $stable(cfg_field))
         || $stable(cfg_rdata)));
endmodule

bind cbag_top cbag_checker #(
    .AW    (AW),
    .SW    (SW),
    .NPORT (NPORT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel  (bank_sel),
    .cfg_we    (cfg_we),
    .cfg_set   (cfg_set),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .gen_req   (gen_req),
    .set0      (gen_set[SW-1:0]),
    .addr0     (gen_addr[AW-1:0]),
    .nxt0      (wr_nxt[AW-1:0]),
    .mod0      (rd_mod[AW-1:0]),
    .base0     (rd_base[AW-1:0]),
    .len0      (rd_len[AW-1:0])
);

// File: tb/tb_cbag_top.sv
module tb_cbag_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_sel = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_set = '0;
    logic [1:0]  cfg_field = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [1:0]  gen_req = '0;
    logic [7:0]  gen_set = '0;
    logic [31:0] gen_addr;

    always #(CLK_P/2) clk = ~clk;

    cbag_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_sel  (bank_sel),
        .cfg_we    (cfg_we),
        .cfg_set   (cfg_set),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .gen_req   (gen_req),
        .gen_set   (gen_set),
        .gen_addr  (gen_addr)
    );

    typedef struct {
        int          kind;   // 0 read-back, 1 port 0 address, 2 port 1 address
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    event  mon_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // bench-side model: [bank][set]
    logic [15:0] m_idx [2][16];
    logic [15:0] m_mod [2][16];
    logic [15:0] m_base[2][16];
    logic [15:0] m_len [2][16];

    function automatic logic [15:0] f_field(int b, int s, int f);
        case (f)
            0:       return m_idx[b][s];
            1:       return m_mod[b][s];
            2:       return m_base[b][s];
            default: return m_len[b][s];
        endcase
    endfunction

    function automatic logic [15:0] f_next(int b, int s);
        int i;
        int mo;
        int ba;
        int le;
        int sum;
        i   = int'(m_idx[b][s]);
        mo  = int'($signed(m_mod[b][s]));
        ba  = int'(m_base[b][s]);
        le  = int'(m_len[b][s]);
        sum = i + mo;
        if (le != 0) begin
            if (sum >= ba + le)  sum = sum - le;
            else if (sum < ba)   sum = sum + le;
        end
        return 16'(sum);
    endfunction

    // monitor: pops the scoreboard at the sample point
    initial begin
        forever begin
            @(mon_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = sb.pop_front();
                act = (it.kind == 0) ? cfg_rdata :
                      (it.kind == 1) ? gen_addr[15:0] : gen_addr[31:16];
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d act=%h exp=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    // driver: one clock cycle of stimulus, expectations pushed first
    task automatic cycle(input int b, input bit we, input int cs, input int cf,
                         input logic [15:0] wd, input logic [1:0] rq,
                         input int s0, input int s1, input string tag);
        logic [15:0] n0;
        logic [15:0] n1;
        @(negedge clk);
        bank_sel  = b[0];
        cfg_we    = we;
        cfg_set   = cs[3:0];
        cfg_field = cf[1:0];
        cfg_wdata = wd;
        gen_req   = rq;
        gen_set   = {s1[3:0], s0[3:0]};
        if (!we)   sb.push_back('{0, f_field(b, cs, cf), tag});
        if (rq[0]) sb.push_back('{1, m_idx[b][s0], tag});
        if (rq[1]) sb.push_back('{2, m_idx[b][s1], tag});
        n0 = f_next(b, s0);
        n1 = f_next(b, s1);
        #(CLK_P/4);
        -> mon_ev;
        @(posedge clk);
        if (rq[1]) m_idx[b][s1] = n1;
        if (rq[0]) m_idx[b][s0] = n0;
        if (we) begin
            case (cf)
                0:       m_idx[b][cs]  = wd;
                1:       m_mod[b][cs]  = wd;
                2:       m_base[b][cs] = wd;
                default: m_len[b][cs]  = wd;
            endcase
        end
        #1;
    endtask

    task automatic wr(input int b, input int s, input int f, input logic [15:0] v, input string tag);
        cycle(b, 1'b1, s, f, v, 2'b00, 0, 0, tag);
    endtask

    task automatic rd(input int b, input int s, input int f, input string tag);
        cycle(b, 1'b0, s, f, 16'h0, 2'b00, 0, 0, tag);
    endtask

    task automatic setup(input int b, input int s, input logic [15:0] i, input logic [15:0] m,
                         input logic [15:0] ba, input logic [15:0] le);
        wr(b, s, 2, ba, "R2");
        wr(b, s, 3, le, "R2");
        wr(b, s, 1, m,  "R2");
        wr(b, s, 0, i,  "R2");
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 16; s++) begin
                m_idx[b][s] = '0; m_mod[b][s] = '0; m_base[b][s] = '0; m_len[b][s] = '0;
            end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents
        for (int b = 0; b < 2; b++)
            for (int f = 0; f < 4; f++) rd(b, 5, f, "R1");

        // R2: write then read back every field
        setup(0, 3, 16'd100, 16'd3, 16'd100, 16'd7);
        for (int f = 0; f < 4; f++) rd(0, 3, f, "R2");

        // R3 R4 R11: step +3 in [100,107), wraps past the top
        for (int k = 0; k < 7; k++) cycle(0, 1'b0, 3, 0, 16'h0, 2'b01, 3, 0, "R3 R4 R11");

        // R5: step -2 in [200,205), wraps below the base
        setup(0, 4, 16'd201, 16'hFFFE, 16'd200, 16'd5);
        for (int k = 0; k < 6; k++) cycle(0, 1'b0, 4, 0, 16'h0, 2'b01, 4, 0, "R5");

        // R6: zero length, linear with modulo rollover
        setup(0, 7, 16'hC000, 16'h4000, 16'd10, 16'd0);
        for (int k = 0; k < 4; k++) cycle(0, 1'b0, 7, 0, 16'h0, 2'b01, 7, 0, "R6");

        // R7: secondary bank is separate
        setup(1, 3, 16'd500, 16'd1, 16'd500, 16'd4);
        for (int k = 0; k < 5; k++) cycle(1, 1'b0, 3, 0, 16'h0, 2'b10, 0, 3, "R7");
        for (int f = 0; f < 4; f++) rd(0, 3, f, "R7");
        rd(1, 3, 0, "R7");

        // R8: both ports, different sets
        for (int k = 0; k < 4; k++) cycle(0, 1'b0, 4, 0, 16'h0, 2'b11, 3, 4, "R8");
        rd(0, 3, 0, "R8");

        // R9: both ports, same set, single step
        for (int k = 0; k < 3; k++) cycle(0, 1'b0, 3, 0, 16'h0, 2'b11, 3, 3, "R9");

        // R10: index write collides with a port-0 update
        cycle(0, 1'b1, 3, 0, 16'd104, 2'b01, 3, 0, "R10");
        rd(0, 3, 0, "R10");
        cycle(0, 1'b1, 4, 0, 16'd203, 2'b10, 0, 4, "R10");
        rd(0, 4, 0, "R10");

        // R12: idle cycles leave state alone
        rd(0, 3, 0, "R12");
        rd(0, 3, 0, "R12");
        rd(1, 3, 1, "R12");

        @(negedge clk);
        gen_req = '0;
        cfg_we  = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule